// File: doc/BRIEF.md
# Two-Wire Control Port for a Supply Regulator

This block is the serial control port of a small supply regulator. A host on a two-wire bus (I2C) addresses it, then either writes one control byte or reads back one or more status bytes. SCL and SDA are oversampled by the system clock through a synchronizer. START and STOP are recovered from SDA edges that occur while SCL is high. The port drives only an active-high pull-down enable for SDA, so the pad stays open-drain.

The written byte carries its own bank select in its top two bits, so there is no sub-address phase. One bank holds the line-compensation, tone-enable and voltage-select controls. The other bank holds the two output enables. The status byte returns the over-temperature and over-load flags next to the current control bits. The flags are inputs only and cannot be written. While the power-good input is low, the port acknowledges nothing, and a write therefore cannot take effect.

Top module: `pwrctl_i2c_slave`

## Requirements
- R1: After a synchronous active-low reset, all five control outputs are 0 and the SDA pull-down enable is 0.
- R2: START (SDA falling while SCL is high) restarts address reception from the first bit, including a repeated START in the middle of a byte. STOP (SDA rising while SCL is high) returns the port to idle with SDA released.
- R3: The address byte is shifted MSB first: the 7-bit address 0001000, then R/W in bit 0 (1 = read, 0 = write). On a match the port pulls SDA low for the ninth clock and holds it low through the whole SCL-high time. On any other address the port never pulls SDA until the next START or STOP.
- R4: While the power-good input is low, neither the address byte nor the data byte is acknowledged, and no control bit changes.
- R5: A write byte with bits [7:6] = 00 loads line-compensation from bit 0, tone-enable from bit 1 and voltage-select from bit 2. Bits [5:3] are ignored.
- R6: A write byte with bits [7:6] = 01 loads output-enable A from bit 0 and output-enable B from bit 1. Bits [5:2] are ignored. A byte with bit 7 = 1 is acknowledged but changes no control bit.
- R7: A write carries exactly one data byte. Any further byte before STOP is neither acknowledged nor applied. Control outputs change only through an acknowledged write.
- R8: A read returns the status byte MSB first. Its layout, from bit 7 down to bit 0, is over-temperature, over-load, 0, output-enable B, output-enable A, voltage-select, tone-enable, line-compensation. The flags are captured at the SCL fall that ends the acknowledge clock before each byte, and a flag change during the byte does not alter it.
- R9: During the host's acknowledge clock after a status byte, the port releases SDA. A host acknowledge (SDA low) starts another status byte. A host not-acknowledge leaves SDA released until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| pgood_i | input | 1 | Power-good; low suppresses every acknowledge |
| ovtemp_i | input | 1 | Over-temperature status flag |
| ovload_i | input | 1 | Over-load status flag |
| lcomp_o | output | 1 | Line-compensation control |
| tone_o | output | 1 | Tone-enable control |
| vsel_o | output | 1 | Voltage-select control |
| en_a_o | output | 1 | Output-enable A |
| en_b_o | output | 1 | Output-enable B |

## Verification
If the bit counter or the state register is off by even one step, the acknowledge lands on the wrong clock. The host then sees a missing or misplaced low on the ninth clock of the same byte, or a status byte shifted by one position. A bad bank decode or a bad power-good gate shows up on the control outputs right after the STOP of the offending write. A wrong flag-capture point shows up as a status byte that follows a flag toggled in the middle of the byte, visible within that byte's eight clocks.

// File: rtl/pwi_pkg.sv
// Package for the two-wire control port.
// Holds the byte-engine state encoding, the bank-select codes and the
// control-bit bundle that the engine and the register bank share.
package pwi_pkg;

    localparam int BITS_PER_BYTE = 8;
    localparam int BIT_W         = $clog2(BITS_PER_BYTE + 1);

    // Bank-select codes carried in bits [7:6] of a written byte
    localparam logic [1:0] SEL_BANK_A = 2'b00;
    localparam logic [1:0] SEL_BANK_B = 2'b01;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // no transaction in progress
        ST_ADDR = 3'd1,   // shifting the address byte in
        ST_AACK = 3'd2,   // driving the address acknowledge
        ST_WDAT = 3'd3,   // shifting the write byte in
        ST_WACK = 3'd4,   // driving the data acknowledge
        ST_RDAT = 3'd5,   // shifting a status byte out
        ST_RACK = 3'd6,   // watching the host acknowledge
        ST_SKIP = 3'd7    // silent until the next START or STOP
    } eng_state_t;

    typedef struct packed {
        logic en_b;
        logic en_a;
        logic vsel;
        logic tone;
        logic lcomp;
    } ctrl_t;

endpackage

// File: rtl/pwi_sync_edge.sv
// Bus line conditioner.
// Brings SCL and SDA into the clock domain through a STAGES-deep flop
// chain, keeps one more delayed copy of each, and decodes SCL rise/fall
// plus START/STOP from that pair. Assumes the bus is much slower than clk
// (several clk periods per SCL phase) and that both lines idle high.
module pwi_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_lvl,
    output logic start_det,
    output logic stop_det
);

    localparam int LINES = 2;   // index 0 = SCL, index 1 = SDA

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] delayed;

    assign raw = {sda_i, scl_i};

    for (genvar gi = 0; gi < LINES; gi++) begin : g_line
        logic [STAGES-1:0] chain;

        // Shift the raw line level through the synchronizer chain
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[gi]};
        end

        assign synced[gi] = chain[STAGES-1];

        // Keep the previous synchronized level for edge decoding
        always_ff @(posedge clk) begin
            if (!rst_n) delayed[gi] <= 1'b1;
            else        delayed[gi] <= synced[gi];
        end
    end

    assign scl_rise  =  synced[0] & ~delayed[0];
    assign scl_fall  = ~synced[0] &  delayed[0];
    assign sda_lvl   =  synced[1];
    assign start_det =  synced[0] & delayed[0] &  delayed[1] & ~synced[1];
    assign stop_det  =  synced[0] & delayed[0] & ~delayed[1] &  synced[1];

endmodule

// File: rtl/pwi_engine.sv
// Byte engine of the two-wire control port.
// Counts bits on SCL rises, moves SDA only on SCL falls, matches the
// device address, gates every acknowledge with power-good, issues a
// one-cycle write strobe for the single data byte and serializes the
// status byte on reads. Assumes conditioned edge pulses from
// pwi_sync_edge, of which at most one is active in any cycle.
module pwi_engine
    import pwi_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h08
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       sda_lvl,
    input  logic       pgood,
    input  logic [7:0] status_byte,
    output logic       sda_oe,
    output logic       wr_stb,
    output logic [1:0] wr_sel,
    output logic [2:0] wr_bits
);

    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BITS_PER_BYTE);

    eng_state_t       st;
    logic [BIT_W-1:0] cnt;
    logic [7:0]       rx_sr;
    logic [7:0]       tx_sr;
    logic             rnw;
    logic             host_ack;
    logic             addr_hit;

    assign addr_hit = (rx_sr[7:1] == DEV_ADDR);
    assign wr_sel   = rx_sr[7:6];
    assign wr_bits  = rx_sr[2:0];

    // Main sequencer: framing, acknowledge, write strobe and read shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            rx_sr    <= '0;
            tx_sr    <= '0;
            rnw      <= 1'b0;
            host_ack <= 1'b0;
            sda_oe   <= 1'b0;
            wr_stb   <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            if (start_det) begin
                st     <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                st     <= ST_IDLE;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    ST_ADDR: begin
                        if (scl_rise && cnt < LAST_BIT) begin
                            rx_sr <= {rx_sr[6:0], sda_lvl};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && cnt == LAST_BIT) begin
                            if (addr_hit && pgood) begin
                                sda_oe <= 1'b1;
                                rnw    <= rx_sr[0];
                                st     <= ST_AACK;
                            end else begin
                                st <= ST_SKIP;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (rnw) begin
                                sda_oe <= ~status_byte[7];
                                tx_sr  <= {status_byte[6:0], 1'b0};
                                st     <= ST_RDAT;
                            end else begin
                                sda_oe <= 1'b0;
                                st     <= ST_WDAT;
                            end
                        end
                    end
                    ST_WDAT: begin
                        if (scl_rise && cnt < LAST_BIT) begin
                            rx_sr <= {rx_sr[6:0], sda_lvl};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && cnt == LAST_BIT) begin
                            if (pgood) begin
                                sda_oe <= 1'b1;
                                wr_stb <= 1'b1;
                                st     <= ST_WACK;
                            end else begin
                                st <= ST_SKIP;
                            end
                        end
                    end
                    ST_WACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            st     <= ST_SKIP;
                        end
                    end
                    ST_RDAT: begin
                        if (scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (cnt == LAST_BIT) begin
                                sda_oe <= 1'b0;
                                st     <= ST_RACK;
                            end else begin
                                sda_oe <= ~tx_sr[7];
                                tx_sr  <= {tx_sr[6:0], 1'b0};
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            host_ack <= ~sda_lvl;
                        end else if (scl_fall) begin
                            if (host_ack) begin
                                cnt    <= '0;
                                sda_oe <= ~status_byte[7];
                                tx_sr  <= {status_byte[6:0], 1'b0};
                                st     <= ST_RDAT;
                            end else begin
                                st <= ST_SKIP;
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

    AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (st == ST_ADDR && cnt == '0)); // R2
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (st == ST_IDLE && !sda_oe)); // R2
    AST_BIT_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_BIT); // R3
    AST_OE_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) && !$past(start_det || stop_det) |-> $past(scl_fall)); // R3
    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SKIP) |-> !sda_oe); // R3
    AST_ACK_NEEDS_PGOOD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) && (st == ST_AACK || st == ST_WACK) |-> $past(pgood)); // R4
    AST_STROBE_NEEDS_PGOOD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(pgood)); // R4
    AST_RACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RACK) |-> !sda_oe); // R9

endmodule

// File: rtl/pwi_regs.sv
// Control register bank of the two-wire control port.
// Applies a write strobe to the bank named by the select field and
// assembles the status byte from the live flags and the current
// controls. Assumes wr_sel and wr_bits are stable while wr_stb is high.
module pwi_regs
    import pwi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stb,
    input  logic [1:0] wr_sel,
    input  logic [2:0] wr_bits,
    input  logic       ovtemp,
    input  logic       ovload,
    output ctrl_t      ctrl,
    output logic [7:0] status_byte
);

    // Update the selected bank on a write strobe; other selects are dropped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_stb) begin
            case (wr_sel)
                SEL_BANK_A: begin
                    ctrl.lcomp <= wr_bits[0];
                    ctrl.tone  <= wr_bits[1];
                    ctrl.vsel  <= wr_bits[2];
                end
                SEL_BANK_B: begin
                    ctrl.en_a <= wr_bits[0];
                    ctrl.en_b <= wr_bits[1];
                end
                default: ;
            endcase
        end
    end

    // Status byte: flags on top, a zero gap, then the control bits
    assign status_byte = {ovtemp, ovload, 1'b0, ctrl.en_b, ctrl.en_a,
                          ctrl.vsel, ctrl.tone, ctrl.lcomp};

    AST_QUIET_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(ctrl)); // R7
    AST_UPPER_SELECT_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_sel[1]) |=> $stable(ctrl)); // R6
    AST_BANK_A_KEEPS_B: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_sel == SEL_BANK_A) |=> $stable({ctrl.en_b, ctrl.en_a})); // R5

endmodule

// File: rtl/pwrctl_i2c_slave.sv
// Top of the two-wire control port for a supply regulator.
// Wires the line conditioner, the byte engine and the register bank,
// and exposes the control bits and the open-drain SDA pull-down enable.
// Assumes the pad drives SDA low when sda_oe_o is 1 and releases it otherwise.
module pwrctl_i2c_slave
    import pwi_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h08,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o,
    input  logic pgood_i,
    input  logic ovtemp_i,
    input  logic ovload_i,
    output logic lcomp_o,
    output logic tone_o,
    output logic vsel_o,
    output logic en_a_o,
    output logic en_b_o
);

    logic       scl_rise;
    logic       scl_fall;
    logic       sda_lvl;
    logic       start_det;
    logic       stop_det;
    logic       wr_stb;
    logic [1:0] wr_sel;
    logic [2:0] wr_bits;
    logic [7:0] status_byte;
    ctrl_t      ctrl;

    pwi_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_lvl   (sda_lvl),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    pwi_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .sda_lvl     (sda_lvl),
        .pgood       (pgood_i),
        .status_byte (status_byte),
        .sda_oe      (sda_oe_o),
        .wr_stb      (wr_stb),
        .wr_sel      (wr_sel),
        .wr_bits     (wr_bits)
    );

    pwi_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb      (wr_stb),
        .wr_sel      (wr_sel),
        .wr_bits     (wr_bits),
        .ovtemp      (ovtemp_i),
        .ovload      (ovload_i),
        .ctrl        (ctrl),
        .status_byte (status_byte)
    );

    assign lcomp_o = ctrl.lcomp;
    assign tone_o  = ctrl.tone;
    assign vsel_o  = ctrl.vsel;
    assign en_a_o  = ctrl.en_a;
    assign en_b_o  = ctrl.en_b;

    AST_RESET_RELEASED: assert property (@(posedge clk)
        !rst_n |=> !sda_oe_o); // R1

endmodule

// File: tb/pwrctl_i2c_slave_tb.sv
// Bench for the two-wire control port: models an open-drain bus and a
// host, runs directed corner cases then seeded random transactions, and
// compares against a bench-side model of the control bits.
module pwrctl_i2c_slave_tb;

    localparam int HP = 8;   // clk cycles per SCL half period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic host_low = 1'b0;
    logic pgood = 1'b1;
    logic ovt = 1'b0;
    logic ovl = 1'b0;
    logic sda_oe;
    logic sda_line;
    logic lcomp, tone, vsel, en_a, en_b;

    logic [2:0] exp_a = '0;  // {vsel, tone, lcomp}
    logic [1:0] exp_b = '0;  // {en_b, en_a}
    int nchk = 0;
    int nerr = 0;

    assign sda_line = !(host_low || sda_oe);

    always #5 clk = ~clk;

    pwrctl_i2c_slave u_dut (
        .clk (clk), .rst_n (rst_n), .scl_i (scl), .sda_i (sda_line),
        .sda_oe_o (sda_oe), .pgood_i (pgood), .ovtemp_i (ovt), .ovload_i (ovl),
        .lcomp_o (lcomp), .tone_o (tone), .vsel_o (vsel),
        .en_a_o (en_a), .en_b_o (en_b)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status();
        return {ovt, ovl, 1'b0, exp_b, exp_a};
    endfunction

    function automatic void model_write(input logic [7:0] d);
        case (d[7:6])
            2'b00: exp_a = d[2:0];
            2'b01: exp_b = d[1:0];
            default: ;
        endcase
    endfunction

    task automatic hclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        host_low = 1'b0; hclk(HP);
        scl = 1'b1;      hclk(HP);
        host_low = 1'b1; hclk(HP);
        scl = 1'b0;      hclk(2);
    endtask

    task automatic bus_stop();
        host_low = 1'b1; hclk(HP - 2);
        scl = 1'b1;      hclk(HP);
        host_low = 1'b0; hclk(HP);
    endtask

    task automatic put_bit(input bit b);
        host_low = !b; hclk(HP - 2);
        scl = 1'b1;    hclk(HP);
        scl = 1'b0;    hclk(2);
    endtask

    task automatic get_bit(output bit v, output bit steady);
        host_low = 1'b0; hclk(HP - 2);
        scl = 1'b1;      hclk(2);
        v = sda_line;    hclk(HP - 2);
        steady = (sda_line == v);
        scl = 1'b0;      hclk(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack, output bit steady);
        bit v;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(v, steady);
        ack = !v;
    endtask

    task automatic recv_byte(output logic [7:0] b);
        bit v, s;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            get_bit(v, s);
            b = {b[6:0], v};
        end
    endtask

    task automatic chk_ctrl(input string req);
        logic [4:0] act, exp;
        act = {en_b, en_a, vsel, tone, lcomp};
        exp = {exp_b, exp_a};
        chk(act == exp, req, act, exp);
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] d,
                            input bit two, input logic [7:0] d2);
        bit ack, st, hit;
        hit = (a == 7'h08) && pgood;
        bus_start();
        send_byte({a, 1'b0}, ack, st);
        chk(ack == hit, "R3/R4 address ack", ack, hit);
        if (ack) chk(st, "R3 ack held low through SCL high", st, 1);
        send_byte(d, ack, st);
        chk(ack == hit, "R4/R3 data ack", ack, hit);
        if (hit) model_write(d);
        if (two) begin
            send_byte(d2, ack, st);
            chk(!ack, "R7 second data byte not acked", ack, 0);
        end
        bus_stop();
        chk_ctrl("R5/R6/R7 controls after write");
    endtask

    task automatic do_read(input logic [6:0] a, input int nbytes);
        bit ack, st, v, s, hit;
        logic [7:0] b;
        hit = (a == 7'h08) && pgood;
        bus_start();
        send_byte({a, 1'b1}, ack, st);
        chk(ack == hit, "R3/R4 read address ack", ack, hit);
        if (ack) begin
            for (int k = 0; k < nbytes; k++) begin
                recv_byte(b);
                chk(b == exp_status(), "R8 status byte", b, exp_status());
                if (k < nbytes - 1) put_bit(1'b0);
                else begin
                    get_bit(v, s);
                    chk(v, "R9 released in host ack clock", v, 1);
                    get_bit(v, s);
                    chk(v, "R9 silent after not-acknowledge", v, 1);
                end
            end
        end else begin
            get_bit(v, s);
            chk(v, "R3 silent when not addressed", v, 1);
        end
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        logic [7:0] b;
        bit ack, st;
        void'($urandom(32'h5EED_0425));
        hclk(6);
        rst_n = 1'b1;
        hclk(4);
        // R1: reset state
        chk_ctrl("R1 controls after reset");
        chk(!sda_oe, "R1 SDA released after reset", sda_oe, 0);

        // R5: bank A, junk in ignored bits
        do_write(7'h08, 8'h07, 0, 0);
        do_write(7'h08, 8'h3D, 0, 0);
        // R6: bank B, then inert selects
        do_write(7'h08, 8'h7F, 0, 0);
        do_write(7'h08, 8'h80, 0, 0);
        do_write(7'h08, 8'hC0, 0, 0);
        do_write(7'h08, 8'h41, 0, 0);
        // R4: power-good low
        pgood = 1'b0;
        do_write(7'h08, 8'h02, 0, 0);
        do_read(7'h08, 1);
        pgood = 1'b1;
        // R3: wrong address
        do_write(7'h09, 8'h00, 0, 0);
        do_write(7'h48, 8'h00, 0, 0);
        // R7: second data byte dropped
        do_write(7'h08, 8'h06, 1, 8'h01);

        // R2: repeated START in the middle of an address byte
        bus_start();
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_start();
        send_byte(8'h10, ack, st);
        chk(ack, "R2 address ack after repeated START", ack, 1);
        send_byte(8'h01, ack, st);
        chk(ack, "R2 data ack after repeated START", ack, 1);
        model_write(8'h01);
        bus_stop();
        chk_ctrl("R2 write after repeated START applied");

        // R8: flag change during a byte; R9 host ack then not-ack
        ovt = 1'b1; ovl = 1'b0;
        bus_start();
        send_byte(8'h11, ack, st);
        chk(ack, "R8 read address ack", ack, 1);
        b = exp_status();
        begin
            logic [7:0] got;
            bit v, s;
            got = '0;
            for (int i = 0; i < 8; i++) begin
                if (i == 3) begin ovt = 1'b0; ovl = 1'b1; end
                get_bit(v, s);
                got = {got[6:0], v};
            end
            chk(got == b, "R8 flags held through byte", got, b);
            put_bit(1'b0);
            recv_byte(got);
            chk(got == exp_status(), "R8/R9 second byte recaptured", got, exp_status());
            get_bit(v, s);
            chk(v, "R9 released in host ack clock", v, 1);
        end
        bus_stop();
        // R8: flags are not writable through any select
        do_write(7'h08, 8'hFF, 0, 0);
        do_read(7'h08, 2);

        // Seeded random mix
        for (int i = 0; i < 40; i++) begin
            logic [6:0] a;
            int op;
            op    = $urandom % 3;
            a     = ($urandom % 4 == 0) ? 7'($urandom) : 7'h08;
            pgood = ($urandom % 5 != 0);
            ovt   = 1'($urandom);
            ovl   = 1'($urandom);
            if (op == 2) do_read(a, 1 + ($urandom % 2));
            else         do_write(a, 8'($urandom), ($urandom % 4 == 0), 8'($urandom));
        end

        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule